// File: doc/BRIEF.md
# Sample-Slope Key Generator with XOR Byte Cipher

This block turns a stream of noisy, unsigned analog-derived sample words into an 8-bit secret key and then uses that key to encrypt or decrypt bytes. Each accepted sample is compared with the sample accepted just before it. A rise or an equal value gives a key bit of one, and a fall gives a zero. The very first sample after reset only provides the reference value for the next comparison. Generated bits enter the key register at its least significant end. The key is complete after eight bits, which takes nine accepted samples. From then on it stays frozen until reset or until a new key is forced in.

Cipher requests XOR the request byte with the key and return the result one cycle later with a valid strobe. Encryption and decryption use the same path: applying the same key a second time recovers the original byte. A request that arrives while no complete key exists is refused with a one-cycle error strobe. For deterministic operation, a load strobe writes a fixed key directly. This marks the key complete and has priority over any sample in the same cycle.

Top module: `slope_key_cipher`

## Requirements
- R1: After reset, key_ready, out_valid and req_err are all 0.
- R2: The first accepted sample after reset yields no key bit; key_ready stays 0 after eight accepted samples and becomes 1 at the clock edge that accepts the ninth.
- R3: A key bit is 1 when the current sample, taken as unsigned, is greater than or equal to the previous accepted sample, and 0 when it is smaller; equal samples give 1.
- R4: Each new bit enters at key bit 0 while older bits move one place toward bit 7, so the first generated bit ends at bit 7 and the eighth at bit 0.
- R5: A cycle with smp_valid low neither advances the bit count nor replaces the reference sample, whatever smp_word holds.
- R6: Once key_ready is 1, further samples leave the key unchanged, and key_ready stays 1 until reset.
- R7: A cycle with key_load high writes key_value into the key and sets key_ready at that edge; it wins over a sample in the same cycle and replaces any earlier key.
- R8: A request (req_valid high) seen while key_ready is 1 gives, one cycle later, out_valid = 1, out_data = req_data XOR key and req_err = 0.
- R9: The same operation decrypts: with key 0x07 the bytes 0x50, 0x4B and 0x55 map to 0x57, 0x4C and 0x52, and those map back to the originals.
- R10: A request seen while key_ready is 0, including one in the same cycle as the event that completes or loads the key, gives req_err = 1 and out_valid = 0 one cycle later.
- R11: out_valid and req_err are never high together, and both are 0 in the cycle after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample word strobe |
| smp_word | input | SAMPLE_W | Unsigned sample value |
| key_load | input | 1 | Force key_value into the key |
| key_value | input | KEY_W | Fixed key for key_load |
| req_valid | input | 1 | Cipher request strobe |
| req_data | input | KEY_W | Plaintext or ciphertext byte |
| key_ready | output | 1 | Key is complete |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | KEY_W | XOR result |
| req_err | output | 1 | Request refused, no key yet |

## Verification
The hardest case to reach is the boundary where a request arrives in the same cycle as the event that completes the key: the ninth sample or a load strobe. The design must refuse that request because the key state is taken before the edge. The bench reaches this case by driving the final sample, or the load, together with a request in one cycle. It then checks for the error strobe, and on the next request for normal data. The key is never read directly. Its value is observed by encrypting 0x00, which must return the key itself.

// File: rtl/skc_pkg.sv
package skc_pkg;
    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_DATA   = 2'd1,
        RES_REJECT = 2'd2
    } result_e;
endpackage

// File: rtl/skc_slope.sv
module skc_slope #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_word,
    output logic                bit_valid,
    output logic                bit_val
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] ref_smp;
        logic                seeded;
    } slope_t;

    slope_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        bit_valid = smp_valid && st_q.seeded;
        bit_val   = (smp_word >= st_q.ref_smp);
        if (smp_valid) begin
            st_d.ref_smp = smp_word;
            st_d.seeded  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/skc_keyreg.sv
module skc_keyreg #(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_val,
    input  logic             key_load,
    input  logic [KEY_W-1:0] key_value,
    output logic [KEY_W-1:0] key,
    output logic             ready
);
    localparam int CNT_W = $clog2(KEY_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_W - 1);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } kreg_t;

    kreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_load) begin
            st_d.key   = key_value;
            st_d.cnt   = CNT_W'(KEY_W);
            st_d.ready = 1'b1;
        end else if (bit_valid && !st_q.ready) begin
            st_d.key = {st_q.key[KEY_W-2:0], bit_val};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key   = st_q.key;
    assign ready = st_q.ready;
endmodule

// File: rtl/skc_xor.sv
module skc_xor
    import skc_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [KEY_W-1:0] req_data,
    input  logic [KEY_W-1:0] key,
    input  logic             key_ready,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_data,
    output logic             req_err
);
    typedef struct packed {
        result_e          res;
        logic [KEY_W-1:0] data;
    } xo_t;

    xo_t st_d, st_q;
    logic [KEY_W-1:0] mixed;

    for (genvar b = 0; b < KEY_W; b++) begin : g_mix
        assign mixed[b] = req_data[b] ^ key[b];
    end

    always_comb begin
        st_d     = st_q;
        st_d.res = RES_NONE;
        if (req_valid) begin
            if (key_ready) begin
                st_d.res  = RES_DATA;
                st_d.data = mixed;
            end else begin
                st_d.res = RES_REJECT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{res: RES_NONE, data: '0};
        else        st_q <= st_d;
    end

    assign out_valid = (st_q.res == RES_DATA);
    assign req_err   = (st_q.res == RES_REJECT);
    assign out_data  = st_q.data;
endmodule

// File: rtl/slope_key_cipher.sv
module slope_key_cipher #(
    parameter int SAMPLE_W = 12,
    parameter int KEY_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_word,
    input  logic                key_load,
    input  logic [KEY_W-1:0]    key_value,
    input  logic                req_valid,
    input  logic [KEY_W-1:0]    req_data,
    output logic                key_ready,
    output logic                out_valid,
    output logic [KEY_W-1:0]    out_data,
    output logic                req_err
);
    logic             bit_valid;
    logic             bit_val;
    logic [KEY_W-1:0] key_w;

    skc_slope #(.SAMPLE_W(SAMPLE_W)) u_slope (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(smp_valid), .smp_word(smp_word),
        .bit_valid(bit_valid), .bit_val(bit_val)
    );

    skc_keyreg #(.KEY_W(KEY_W)) u_keyreg (
        .clk(clk), .rst_n(rst_n),
        .bit_valid(bit_valid), .bit_val(bit_val),
        .key_load(key_load), .key_value(key_value),
        .key(key_w), .ready(key_ready)
    );

    skc_xor #(.KEY_W(KEY_W)) u_xor (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_data(req_data),
        .key(key_w), .key_ready(key_ready),
        .out_valid(out_valid), .out_data(out_data), .req_err(req_err)
    );
endmodule

// File: rtl/slope_key_cipher_chk.sv
module slope_key_cipher_chk #(
    parameter int KEY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_load,
    input logic [KEY_W-1:0] key_value,
    input logic             req_valid,
    input logic [KEY_W-1:0] req_data,
    input logic             key_ready,
    input logic             out_valid,
    input logic [KEY_W-1:0] out_data,
    input logic             req_err,
    input logic [KEY_W-1:0] key_w
);
    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && req_err));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !req_err));

    assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !key_ready) |=> (req_err && !out_valid));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && key_ready) |=> (out_valid && out_data == $past(req_data ^ key_w)));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> (key_ready && key_w == $past(key_value)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        key_ready |=> key_ready);

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ready && !key_load) |=> $stable(key_w));
endmodule

bind slope_key_cipher slope_key_cipher_chk #(.KEY_W(KEY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_value(key_value),
    .req_valid(req_valid), .req_data(req_data), .key_ready(key_ready),
    .out_valid(out_valid), .out_data(out_data), .req_err(req_err), .key_w(key_w)
);

// File: tb/tb_slope_key_cipher.sv
module tb_slope_key_cipher;
    localparam int SW = 12;
    localparam int KW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_word = '0;
    logic          key_load = 1'b0;
    logic [KW-1:0] key_value = '0;
    logic          req_valid = 1'b0;
    logic [KW-1:0] req_data = '0;
    logic          key_ready, out_valid, req_err;
    logic [KW-1:0] out_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [SW-1:0] m_prev;
    logic          m_seeded;
    logic [KW-1:0] m_key;
    int            m_cnt;

    always #4 clk = ~clk;

    slope_key_cipher #(.SAMPLE_W(SW), .KEY_W(KW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
        .key_load(key_load), .key_value(key_value), .req_valid(req_valid),
        .req_data(req_data), .key_ready(key_ready), .out_valid(out_valid),
        .out_data(out_data), .req_err(req_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 0; key_load = 0; req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_seeded = 0; m_key = '0; m_cnt = 0; m_prev = '0;
    endtask

    // drive one sample (optionally with a request); returns after the edge
    task automatic sample(input logic [SW-1:0] w, input bit with_req);
        smp_valid = 1'b1; smp_word = w;
        req_valid = with_req; req_data = 8'h00;
        @(negedge clk);
        smp_valid = 1'b0; req_valid = 1'b0; smp_word = ~w;
        if (m_seeded && m_cnt < KW) begin
            m_key = {m_key[KW-2:0], (w >= m_prev)};
            m_cnt++;
        end
        m_prev = w; m_seeded = 1'b1;
    endtask

    task automatic cipher(input logic [KW-1:0] d, output logic [KW-1:0] r, output logic v, output logic e);
        req_valid = 1'b1; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        r = out_data; v = out_valid; e = req_err;
    endtask

    task automatic expect_key(input string req, input logic [KW-1:0] k);
        logic [KW-1:0] r; logic v, e;
        cipher(8'h00, r, v, e);
        chk({req, " valid"}, v, 1);
        chk({req, " key"}, r, k);
        chk({req, " no err"}, e, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 key_ready", key_ready, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 req_err", req_err, 0);
    endtask

    task automatic t_generate();
        logic [SW-1:0] s[9] = '{12'd100, 12'd120, 12'd120, 12'd90, 12'd300,
                                12'd299, 12'd4095, 12'd0, 12'd5};
        logic [KW-1:0] r; logic v, e;
        do_reset();
        for (int i = 0; i < 8; i++) begin
            sample(s[i], 0);
            @(negedge clk);  // idle cycle with junk word: R5
            if (i == 3) begin
                cipher(8'h3C, r, v, e);
                chk("R10 early req err", e, 1);
                chk("R10 early req no valid", v, 0);
            end
        end
        chk("R2 not ready after 8 samples", key_ready, 0);
        sample(s[8], 0);
        chk("R2 ready after 9th sample", key_ready, 1);
        chk("R3 R4 model key", m_key, 8'hD5);
        expect_key("R4 key D5", 8'hD5);
        sample(12'd0, 0);
        sample(12'd4000, 0);
        expect_key("R6 key frozen", 8'hD5);
        chk("R6 still ready", key_ready, 1);
        @(negedge clk);
        chk("R11 idle no valid", out_valid, 0);
        chk("R11 idle no err", req_err, 0);
    endtask

    task automatic t_pattern(input string req, input int mode);
        logic [SW-1:0] w;
        do_reset();
        for (int i = 0; i < 9; i++) begin
            case (mode)
                0: w = 12'd777;
                1: w = SW'(4000 - 400 * i);
                default: w = (i % 2 == 0) ? SW'(10 + i) : SW'(2000 - i);
            endcase
            sample(w, 0);
        end
        chk({req, " ready"}, key_ready, 1);
        expect_key(req, m_key);
    endtask

    task automatic t_same_cycle_sample();
        logic [KW-1:0] r; logic v, e;
        do_reset();
        for (int i = 0; i < 8; i++) sample(SW'(i * 3), 0);
        sample(12'd1, 1);
        chk("R10 req with 9th sample err", req_err, 1);
        chk("R10 req with 9th sample no valid", out_valid, 0);
        chk("R2 ready", key_ready, 1);
        cipher(8'hA5, r, v, e);
        chk("R8 next req valid", v, 1);
        chk("R8 next req data", r, 8'hA5 ^ m_key);
    endtask

    task automatic t_load();
        logic [KW-1:0] r; logic v, e;
        logic [KW-1:0] pt[3] = '{8'h50, 8'h4B, 8'h55};
        logic [KW-1:0] ct[3] = '{8'h57, 8'h4C, 8'h52};
        do_reset();
        sample(12'd50, 0);
        // load together with a sample and a request
        key_load = 1'b1; key_value = 8'h07;
        smp_valid = 1'b1; smp_word = 12'd10;
        req_valid = 1'b1; req_data = 8'h11;
        @(negedge clk);
        key_load = 0; smp_valid = 0; req_valid = 0;
        chk("R10 req with load err", req_err, 1);
        chk("R7 load sets ready", key_ready, 1);
        for (int i = 0; i < 3; i++) begin
            cipher(pt[i], r, v, e);
            chk("R9 encrypt", r, ct[i]);
            chk("R8 valid", v, 1);
            cipher(ct[i], r, v, e);
            chk("R9 decrypt", r, pt[i]);
        end
        key_load = 1'b1; key_value = 8'hC3;
        @(negedge clk);
        key_load = 1'b0;
        expect_key("R7 reload", 8'hC3);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_generate();
        t_pattern("R3 equal samples all ones", 0);
        chk("R3 equal gives FF", m_key, 8'hFF);
        t_pattern("R3 falling samples all zeros", 1);
        chk("R3 falling gives 00", m_key, 8'h00);
        t_pattern("R4 alternating", 2);
        t_same_cycle_sample();
        t_load();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule